// File: doc/BRIEF.md
# Serial Management Command Bridge

The bridge lets a host reach registers inside an external expander over a two-wire serial management link through one 32-bit command word. Software writes the word with its execute bit set. The bridge then sends one management frame on the MDC/MDIO pair. On a read it captures the 16 returned bits into the upper half of the same word. When the frame ends it clears the execute bit. Software polls that bit to learn when the transaction has finished.

The target's bus address, the register address, the direction and the write data all travel in the command word. The read result comes back in the same word. A separate sticky flag reports a target that never drove the turnaround slot of a read. The MDC rate is set by a divider parameter, and the length of the all-ones preamble is also a parameter.

Top module: `mgmt_cmd_bridge`

## Requirements
- R1: After reset the command word reads 0, MDC is low, MDIO output enable is low and the error flag is low.
- R2: The command word has fixed fields. Bit 0 is execute. Bit 1 selects the operation (1 = write, 0 = read). Bits 6:2 are the target bus address. Bits 11:7 are the register address. Bits 31:16 are the data. Bits 15:12 always read as zero. The register port accepts an access in the cycle it is presented: ready follows valid. A write with bit 0 set while idle starts a transaction, and execute reads as 1 from the next cycle.
- R3: Each transaction sends, in this order: PRE_LEN ones, start code 01, opcode 01 for a write or 10 for a read, the 5-bit bus address MSB first, and the 5-bit register address MSB first.
- R4: A write frame continues with turnaround bits 1 then 0, followed by bits 31:16 MSB first. The bridge drives MDIO for the whole frame.
- R5: A read frame releases MDIO (output enable low) from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround, MSB first, are stored in bits 31:16.
- R6: The execute bit clears by itself once the frame is complete. Bits 11:1 keep the values written.
- R7: A write to the command word while execute is set is ignored.
- R8: If MDIO is high when the second turnaround bit of a read is sampled, the error flag is set and bits 31:16 read 0xFFFF. The flag stays set until the next write that starts a transaction, and that write clears it.
- R9: MDC is low whenever execute is clear. During a frame MDC has a period of 2*MDC_HALF clocks. While driven, MDIO changes only in the cycle in which MDC falls, and it is sampled when MDC rises.
- R10: A write with bit 0 clear, made while idle, loads the other fields and starts no transaction. MDC and MDIO stay quiet, and the error flag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write the command word, 0 = read |
| reg_wdata_i | input | 32 | Command word to write |
| reg_ready_o | output | 1 | Access accepted |
| reg_rdata_o | output | 32 | Current command word |
| err_o | output | 1 | Sticky no-response flag |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench plays the part of the expander. It decodes each frame bit by bit on MDC rising edges and answers reads on falling edges. A bridge that swapped the address fields, sent the wrong opcode, or kept driving through the turnaround shows up as a mismatched frame field or a high output enable. The bench also re-issues a command while the first is busy. A bridge that accepted that write would send or report the second set of addresses. A read with no target attached must raise the flag and return all ones. A load without execute must leave that flag set, and the next real command must clear it, so a flag that was not sticky, or that cleared on any write, is caught. Boundary values are tried as well: bus address 0x1F, register address 0x1F, and data patterns of all zeros and all ones.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned HDR_W    = 2 + 2 + ADDR_W + ADDR_W + 2;
  localparam int unsigned WORD_W   = HDR_W + DATA_W;
  // command word layout
  localparam int unsigned OP_BIT   = 1;
  localparam int unsigned BUS_LSB  = 2;
  localparam int unsigned REG_LSB  = BUS_LSB + ADDR_W;
  localparam int unsigned GAP_LSB  = REG_LSB + ADDR_W;
  localparam int unsigned DATA_LSB = WORD_W - DATA_W;
  localparam int unsigned GAP_W    = DATA_LSB - GAP_LSB;
  // frame codes
  localparam logic [1:0] ST_CODE = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] reg_a;
    logic [ADDR_W-1:0] bus_a;
    logic              wr;
  } cmd_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_PRE, ENG_FRAME} eng_state_e;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int unsigned HALF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i & tick & ~mdc_q;
  assign fall_o = run_i & tick & mdc_q;
endmodule

// File: rtl/mgmt_frame_eng.sv
module mgmt_frame_eng
  import mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              done_o,
  output logic              ta_err_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int unsigned PW     = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam int unsigned FW     = $clog2(WORD_W);
  localparam int unsigned TA_POS = HDR_W - 2;
  localparam int unsigned TA_CHK = HDR_W - 1;

  eng_state_e        state_q;
  logic [PW-1:0]     pre_q;
  logic [FW-1:0]     pos_q;
  logic [WORD_W-1:0] sh_q;
  logic              wr_q;
  logic [DATA_W-1:0] rd_q;
  logic              err_q;
  logic              done_q;
  logic              drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      pre_q   <= '0;
      pos_q   <= '0;
      sh_q    <= '0;
      wr_q    <= 1'b0;
      rd_q    <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ENG_IDLE: begin
          if (start_i) begin
            state_q <= ENG_PRE;
            pre_q   <= '0;
            pos_q   <= '0;
            wr_q    <= cmd_i.wr;
            err_q   <= 1'b0;
            rd_q    <= '0;
            sh_q    <= {ST_CODE, (cmd_i.wr ? OP_WR : OP_RD), cmd_i.bus_a,
                        cmd_i.reg_a, TA_WR, (cmd_i.wr ? cmd_i.data : '0)};
          end
        end
        ENG_PRE: begin
          if (fall_i) begin
            if (pre_q == PW'(PRE_LEN - 1)) state_q <= ENG_FRAME;
            else                           pre_q   <= pre_q + 1'b1;
          end
        end
        ENG_FRAME: begin
          if (rise_i && !wr_q) begin
            // target must pull the second turnaround bit low
            if (pos_q == FW'(TA_CHK)) err_q <= mdio_i;
            if (pos_q >= FW'(HDR_W))  rd_q  <= {rd_q[DATA_W-2:0], mdio_i};
          end
          if (fall_i) begin
            if (pos_q == FW'(WORD_W - 1)) begin
              state_q <= ENG_IDLE;
              done_q  <= 1'b1;
            end else begin
              pos_q <= pos_q + 1'b1;
              sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            end
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign drive     = (state_q == ENG_PRE) ||
                     ((state_q == ENG_FRAME) && (wr_q || (pos_q < FW'(TA_POS))));
  assign mdio_oe_o = drive;
  assign mdio_o    = drive & ((state_q == ENG_PRE) | sh_q[WORD_W-1]);
  assign run_o     = (state_q != ENG_IDLE);
  assign done_o    = done_q;
  assign ta_err_o  = err_q;
  assign rd_data_o = err_q ? '1 : rd_q;
endmodule

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg
  import mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              ta_err_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              start_o,
  output cmd_t              start_cmd_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              err_o
);
  cmd_t cmd_q;
  cmd_t wcmd;
  logic exec_q;
  logic err_q;
  logic wr_acc;
  logic unused_gap;

  assign unused_gap = ^wdata_i[GAP_LSB +: GAP_W];

  always_comb begin
    wcmd.wr    = wdata_i[OP_BIT];
    wcmd.bus_a = wdata_i[BUS_LSB +: ADDR_W];
    wcmd.reg_a = wdata_i[REG_LSB +: ADDR_W];
    wcmd.data  = wdata_i[DATA_LSB +: DATA_W];
  end

  // writes while busy are dropped
  assign wr_acc      = valid_i & write_i & ~exec_q;
  assign start_o     = wr_acc & wdata_i[0];
  assign start_cmd_o = wcmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      exec_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (wr_acc) begin
      cmd_q  <= wcmd;
      exec_q <= wdata_i[0];
      if (wdata_i[0]) err_q <= 1'b0;
    end else if (done_i) begin
      exec_q <= 1'b0;
      err_q  <= ta_err_i;
      if (!cmd_q.wr) cmd_q.data <= rd_data_i;
    end
  end

  assign rdata_o = {cmd_q.data, {GAP_W{1'b0}}, cmd_q.reg_a, cmd_q.bus_a, cmd_q.wr, exec_q};
  assign err_o   = err_q;
endmodule

// File: rtl/mgmt_cmd_bridge.sv
module mgmt_cmd_bridge
  import mgmt_pkg::*;
#(
  parameter int unsigned MDC_HALF = 3,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_valid_i,
  input  logic        reg_write_i,
  input  logic [31:0] reg_wdata_i,
  output logic        reg_ready_o,
  output logic [31:0] reg_rdata_o,
  output logic        err_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              eng_start;
  cmd_t              eng_cmd;
  logic              eng_run;
  logic              eng_done;
  logic              eng_err;
  logic [DATA_W-1:0] eng_rd;
  logic              mdc_rise;
  logic              mdc_fall;

  assign reg_ready_o = reg_valid_i;

  mgmt_cmd_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (reg_valid_i),
    .write_i     (reg_write_i),
    .wdata_i     (reg_wdata_i),
    .done_i      (eng_done),
    .ta_err_i    (eng_err),
    .rd_data_i   (eng_rd),
    .start_o     (eng_start),
    .start_cmd_o (eng_cmd),
    .rdata_o     (reg_rdata_o),
    .err_o       (err_o)
  );

  mgmt_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (eng_run),
    .mdc_o  (mdc_o),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mgmt_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .cmd_i     (eng_cmd),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .mdio_i    (mdio_i),
    .run_o     (eng_run),
    .done_o    (eng_done),
    .ta_err_o  (eng_err),
    .rd_data_o (eng_rd),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mgmt_bridge_chk.sv
module mgmt_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        write_i,
  input logic        wexec_i,
  input logic [11:0] cfg_i,
  input logic        err_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        mdio_oe_i,
  input logic        done_i
);
  // R2
  start_sets_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && wexec_i && !cfg_i[0]) |=> cfg_i[0]);

  // R6
  exec_clear_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_i[0]) |-> $past(done_i));

  // R7
  busy_write_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && cfg_i[0]) |=> $stable(cfg_i[11:1]));

  // R8
  err_rise_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $fell(cfg_i[0]));

  // R9
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[0] |-> !mdc_i);

  // R9
  mdio_moves_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_i && $past(mdio_oe_i) && !$stable(mdio_i)) |-> $fell(mdc_i));
endmodule

bind mgmt_cmd_bridge mgmt_bridge_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (reg_valid_i),
  .write_i   (reg_write_i),
  .wexec_i   (reg_wdata_i[0]),
  .cfg_i     (reg_rdata_o[11:0]),
  .err_i     (err_o),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .mdio_oe_i (mdio_oe_o),
  .done_i    (eng_done)
);

// File: tb/sim_mgmt_cmd_bridge.sv
module sim_mgmt_cmd_bridge;
  localparam int HALF = 3;
  localparam int PRE  = 32;
  localparam int TOT  = PRE + 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready;
  logic [31:0] reg_rdata;
  logic        err;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mgmt_cmd_bridge #(.MDC_HALF(HALF), .PRE_LEN(PRE)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_valid_i (reg_valid),
    .reg_write_i (reg_write),
    .reg_wdata_i (reg_wdata),
    .reg_ready_o (reg_ready),
    .reg_rdata_o (reg_rdata),
    .err_o       (err),
    .mdc_o       (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (mdio_i)
  );

  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  logic fr_bit [TOT];
  logic fr_oe  [TOT];
  int   t_r0, t_r1;

  // behavioural register model, compared every clock while idle
  logic        mdl_on = 1'b0;
  logic [31:0] mdl_reg = '0;
  logic        mdl_err = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 gap bits zero", {28'b0, reg_rdata[15:12]}, 32'h0);
      if (mdl_on) begin
        chk("R6 model register", reg_rdata, mdl_reg);
        chk("R8 model error flag", {31'b0, err}, {31'b0, mdl_err});
        chk("R9 idle mdc low", {31'b0, mdc}, 32'h0);
      end
    end
  end

  task automatic reg_wr(input logic [31:0] w);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  function automatic logic rsp_bit(input int f, input logic [15:0] v);
    if (f == 15) return 1'b0;
    if (f >= 16) return v[31-f];
    return 1'b1;
  endfunction

  function automatic logic [15:0] fld(input int off, input int len);
    logic [15:0] v = '0;
    for (int i = 0; i < len; i++) v = {v[14:0], fr_bit[PRE+off+i]};
    return v;
  endfunction

  // expander model: sample on MDC rise, answer on MDC fall
  task automatic serve(input bit respond, input logic [15:0] rdv);
    bit is_rd = 1'b0;
    for (int k = 0; k < TOT; k++) begin
      @(posedge mdc);
      fr_bit[k] = mdio_o;
      fr_oe[k]  = mdio_oe;
      if (k == 0) t_r0 = cyc;
      if (k == 1) t_r1 = cyc;
      if (k == PRE + 3) is_rd = fr_bit[PRE+2] && !fr_bit[PRE+3];
      if (is_rd && respond && k >= PRE + 13 && k < TOT - 1) begin
        @(negedge mdc);
        mdio_i = rsp_bit(k - PRE + 1, rdv);
      end
    end
    mdio_i = 1'b1;
  endtask

  task automatic run_cmd(input logic [31:0] w, input bit respond, input logic [15:0] rdv,
                         input bit busy_wr, input logic [31:0] bw);
    logic [15:0] exp_d;
    logic [31:0] exp_r;
    logic        exp_e;
    logic        pre_ok;
    logic        oe_ok;
    int          polls = 0;
    mdl_on = 1'b0;
    fork
      serve(respond, rdv);
      begin
        reg_wr(w);
        chk("R2 exec set after start", {31'b0, reg_rdata[0]}, 32'h1);
        chk("R8 error cleared by new command", {31'b0, err}, 32'h0);
        if (busy_wr) begin
          reg_wr(bw);
          chk("R7 busy write ignored", reg_rdata, {w[31:16], 4'b0, w[11:1], 1'b1});
        end
        while (reg_rdata[0] && polls < 5000) begin
          @(negedge clk);
          polls++;
        end
        chk("R6 exec clears within poll limit", {31'b0, reg_rdata[0]}, 32'h0);
      end
    join
    pre_ok = 1'b1;
    for (int k = 0; k < PRE; k++) if (fr_bit[k] !== 1'b1 || fr_oe[k] !== 1'b1) pre_ok = 1'b0;
    chk("R3 preamble ones", {31'b0, pre_ok}, 32'h1);
    chk("R3 start code", {16'b0, fld(0, 2)}, 32'h1);
    chk("R3 opcode", {16'b0, fld(2, 2)}, w[1] ? 32'h1 : 32'h2);
    chk("R3 bus address", {16'b0, fld(4, 5)}, {27'b0, w[6:2]});
    chk("R3 register address", {16'b0, fld(9, 5)}, {27'b0, w[11:7]});
    chk("R9 mdc period", t_r1 - t_r0, 2 * HALF);
    oe_ok = 1'b1;
    if (w[1]) begin
      chk("R4 turnaround", {16'b0, fld(14, 2)}, 32'h2);
      chk("R4 write data", {16'b0, fld(16, 16)}, {16'b0, w[31:16]});
      for (int k = 0; k < TOT; k++) if (fr_oe[k] !== 1'b1) oe_ok = 1'b0;
      chk("R4 driven whole frame", {31'b0, oe_ok}, 32'h1);
    end else begin
      for (int k = 0; k < TOT; k++)
        if (fr_oe[k] !== ((k < PRE + 14) ? 1'b1 : 1'b0)) oe_ok = 1'b0;
      chk("R5 line released from turnaround", {31'b0, oe_ok}, 32'h1);
    end
    exp_d = w[1] ? w[31:16] : (respond ? rdv : 16'hFFFF);
    exp_e = !w[1] && !respond;
    exp_r = {exp_d, 4'b0, w[11:1], 1'b0};
    chk("R5 read data field", {16'b0, reg_rdata[31:16]}, {16'b0, exp_d});
    chk("R6 final register", reg_rdata, exp_r);
    chk("R8 error flag after frame", {31'b0, err}, {31'b0, exp_e});
    mdl_reg = exp_r;
    mdl_err = exp_e;
    mdl_on  = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] w0;
    bit          quiet;
    repeat (3) @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset mdc/oe/err", {29'b0, mdc, mdio_oe, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after release", reg_rdata, 32'h0);
    reg_valid = 1'b1; reg_write = 1'b0;
    #0 chk("R2 ready follows valid", {31'b0, reg_ready}, 32'h1);
    @(negedge clk);
    reg_valid = 1'b0;
    chk("R2 read access no effect", reg_rdata, 32'h0);
    mdl_on = 1'b1;

    // write, max bus address
    run_cmd({16'hA5C3, 4'b0, 5'h05, 5'h1F, 1'b1, 1'b1}, 1'b1, 16'h0, 1'b0, '0);
    // read, max register address
    run_cmd({16'h0000, 4'b0, 5'h1F, 5'h03, 1'b0, 1'b1}, 1'b1, 16'h1234, 1'b0, '0);
    // read with a write dropped while busy
    run_cmd({16'h0000, 4'b0, 5'h0C, 5'h11, 1'b0, 1'b1}, 1'b1, 16'hFFFF, 1'b1,
            {16'h5555, 4'b0, 5'h02, 5'h04, 1'b1, 1'b1});
    // read with no target
    run_cmd({16'h0000, 4'b0, 5'h07, 5'h09, 1'b0, 1'b1}, 1'b0, 16'h0, 1'b0, '0);

    // R10 load without execute
    mdl_on = 1'b0;
    w0 = {16'hBEEF, 4'hF, 5'h0A, 5'h15, 1'b1, 1'b0};
    reg_wr(w0);
    chk("R10 fields loaded, no start", reg_rdata, {16'hBEEF, 4'h0, 5'h0A, 5'h15, 1'b1, 1'b0});
    chk("R8 error sticky across load", {31'b0, err}, 32'h1);
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) quiet = 1'b0;
    end
    chk("R10 link stays quiet", {31'b0, quiet}, 32'h1);
    mdl_reg = {16'hBEEF, 4'h0, 5'h0A, 5'h15, 1'b1, 1'b0};
    mdl_err = 1'b1;
    mdl_on  = 1'b1;

    // next command clears flag; zero data patterns
    run_cmd({16'h0000, 4'b0, 5'h00, 5'h00, 1'b1, 1'b1}, 1'b1, 16'h0, 1'b0, '0);
    run_cmd({16'h0000, 4'b0, 5'h10, 5'h01, 1'b0, 1'b1}, 1'b1, 16'h0000, 1'b0, '0);
    run_cmd({16'hFFFF, 4'b0, 5'h1F, 5'h1F, 1'b1, 1'b1}, 1'b1, 16'h0, 1'b0, '0);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end
endmodule